// File: doc/BRIEF.md
# Straddled Packet Framing Checker

This block watches a 256-bit receive beat stream and its 46-bit sideband word and checks that the packet framing they describe is consistent. One beat can hold the tail of one packet and the head of the next, or two complete short packets. Each packet starts on dword 0 or dword 4. Its end is given as the index of its last dword in the beat. The checker decodes start and end flags, start pointers, end offsets, abort flags and per-byte odd parity. It keeps track of whether a packet is still open across beats.

For every beat that it accepts, the block reports one clock cycle later. The report holds a framing-error pulse, a parity-error pulse, one completion strobe per packet ending in that beat with a good/aborted verdict for it, the open/closed state and a running count of completed packets. A packet is reported as not good when it was discontinued or when any byte inside it failed parity, in any beat it occupied.

Top module: `straddle_frame_checker`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every output is zero and no packet is open.
- R2: Sideband and data are ignored when `in_valid` is low: the next cycle shows no error pulse and no completion, and `pkt_open` and `pkt_count` keep their values.
- R3: Start flags (bits 1:0) and end flags (bits 5:4) are encoded as 00 none, 01 one, 11 two. The value 10 in either field is a framing error.
- R4: A start pointer (bit 2 first start, bit 3 second start) of 0 places the packet's first byte at dword 0, and 1 places it at dword 4. With two starts in one beat, the first pointer must be 0 and the second must be 1, or a framing error is reported.
- R5: A start with no end of the open packet in the same beat, or an end while no packet is open, is a framing error. A beat with a framing error reports no completions, leaves `pkt_count` unchanged and leaves the tracker closed.
- R6: End offsets (bits 10:8 first end, bits 13:11 second end) give the last dword index. An end that precedes a start in the same beat must lie below that start's dword. An end that closes a packet started in the same beat must lie at or above its start dword. Any other case is a framing error.
- R7: One cycle after an accepted beat, `done_vld[k]` is set for each end flag k, and `pkt_count` has grown by the number of ends.
- R8: Parity bit i (sideband bit 14+i) must make the XOR of data byte i (bits 8i+7:8i) and itself equal 1. Any mismatch in a valid beat raises `parity_err` one cycle later.
- R9: A parity mismatch clears the good verdict of the packet whose dwords hold the byte, including a packet that ends in a later beat.
- R10: Discontinue bit k (bits 7:6) marks as aborted the k-th packet present in the beat, where the packet still open from earlier comes first. The abort is held until that packet ends and clears its `done_good` bit.
- R11: `pkt_open` shows, one cycle after each accepted beat, whether a packet remains open at the end of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier |
| in_data | input | 256 | Beat data, byte i at bits 8i+7:8i |
| in_side | input | 46 | Sideband: flags, pointers, offsets, parity |
| frame_err | output | 1 | Framing error in the previous accepted beat |
| parity_err | output | 1 | Byte parity mismatch in the previous accepted beat |
| done_vld | output | 2 | Completion strobe per end slot |
| done_good | output | 2 | Verdict per completed packet, 1 = good |
| pkt_open | output | 1 | A packet spans past the last accepted beat |
| pkt_count | output | 16 | Completed packets, wrapping |

## Verification
The bench targets the beats where packets share space. These are end-then-start and start-then-end with offsets on both sides of the start dword, and two starts with the wrong pointer pair. A checker that compared offsets the wrong way or ignored pointers would flag legal beats or accept overlapping packets. It also places parity faults on either side of the dword-4 boundary and in an earlier beat of a multi-beat packet. Wrong lane blame or a dropped sticky flag would give the wrong good bit. Beats with valid low that carry illegal sideband show whether the block samples only qualified beats.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Beat geometry
    localparam int DATA_W  = 256;
    localparam int BYTES   = DATA_W / 8;
    localparam int DWORDS  = DATA_W / 32;
    localparam int HALF    = DWORDS / 2;
    localparam int OFF_W   = $clog2(DWORDS);

    // Sideband geometry: 8 flag bits, two end offsets, then byte parity
    localparam int PAR_LSB = 8 + 2 * OFF_W;
    localparam int SIDE_W  = PAR_LSB + BYTES;

    // Control part of the sideband word, MSB first
    typedef struct packed {
        logic [OFF_W-1:0] eoff1;
        logic [OFF_W-1:0] eoff0;
        logic [1:0]       disc;
        logic [1:0]       eop;
        logic             sptr1;
        logic             sptr0;
        logic [1:0]       sop;
    } side_t;

    // Outcome of one beat as seen by the framing rules
    typedef struct packed {
        logic       err;
        logic [1:0] done;
        logic [1:0] good;
        logic       open_nxt;
        logic       acc_nxt;
    } verdict_t;

    function automatic logic byte_odd_ok(input logic [7:0] b, input logic p);
        return ^{b, p};
    endfunction

endpackage

// File: rtl/sfc_parity.sv
module sfc_parity
    import sfc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [BYTES-1:0]  par,
    output logic [DWORDS-1:0] dw_bad
);
    logic [BYTES-1:0] byte_bad;

    generate
        for (genvar i = 0; i < BYTES; i++) begin : g_byte
            assign byte_bad[i] = !byte_odd_ok(data[8*i +: 8], par[i]);
        end
        for (genvar j = 0; j < DWORDS; j++) begin : g_dw
            assign dw_bad[j] = |byte_bad[4*j +: 4];
        end
    endgenerate

endmodule

// File: rtl/sfc_frame_rules.sv
module sfc_frame_rules
    import sfc_pkg::*;
(
    input  side_t             f,
    input  logic              cont,
    input  logic              acc_bad,
    input  logic [DWORDS-1:0] dw_bad,
    output verdict_t          v
);
    logic [OFF_W-1:0] sdw0;
    logic [OFF_W-1:0] bnd;
    logic             ok;
    logic             open_n;
    logic             keep1;
    logic             lane1;
    logic             par0;
    logic             par1;
    logic             bad0;
    logic             bad1;

    // Legality of the beat given the open state entering it
    always_comb begin
        ok     = 1'b0;
        open_n = 1'b0;
        keep1  = 1'b0;
        sdw0   = f.sptr0 ? OFF_W'(HALF) : '0;
        case ({cont, f.sop, f.eop})
            5'b1_00_00: begin ok = 1'b1; open_n = 1'b1; end
            5'b1_00_01: ok = 1'b1;
            5'b1_01_01: begin ok = (f.eoff0 < sdw0); open_n = 1'b1; keep1 = 1'b1; end
            5'b1_01_11: ok = (f.eoff0 < sdw0) && (f.eoff1 >= sdw0);
            5'b0_00_00: ok = 1'b1;
            5'b0_01_00: begin ok = 1'b1; open_n = 1'b1; end
            5'b0_01_01: ok = (f.eoff0 >= sdw0);
            5'b0_11_01: begin ok = (f.eoff0 < OFF_W'(HALF)); open_n = 1'b1; keep1 = 1'b1; end
            5'b0_11_11: ok = (f.eoff0 < OFF_W'(HALF)) && (f.eoff1 >= OFF_W'(HALF));
            default:    ok = 1'b0;
        endcase
        if (f.sop == 2'b11 && (f.sptr0 || !f.sptr1))
            ok = 1'b0;
    end

    // Split dwords between the first and second packet of the beat
    always_comb begin
        lane1 = (cont && f.sop[0]) || (f.sop == 2'b11);
        bnd   = cont ? sdw0 : OFF_W'(HALF);
        par0  = 1'b0;
        par1  = 1'b0;
        for (int j = 0; j < DWORDS; j++) begin
            if (lane1 && OFF_W'(j) >= bnd)
                par1 = par1 | dw_bad[j];
            else
                par0 = par0 | dw_bad[j];
        end
        bad0 = f.disc[0] | par0 | (cont & acc_bad);
        bad1 = (f.disc[1] & lane1) | par1;
    end

    always_comb begin
        v.err      = !ok;
        v.done     = ok ? f.eop : 2'b00;
        v.good     = (ok ? f.eop : 2'b00) & ~{bad1, bad0};
        v.open_nxt = ok & open_n;
        v.acc_nxt  = keep1 ? bad1 : bad0;
    end

endmodule

// File: rtl/straddle_frame_checker.sv
module straddle_frame_checker
    import sfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SIDE_W-1:0] in_side,
    output logic              frame_err,
    output logic              parity_err,
    output logic [1:0]        done_vld,
    output logic [1:0]        done_good,
    output logic              pkt_open,
    output logic [CNT_W-1:0]  pkt_count
);
    side_t             fields;
    logic [DWORDS-1:0] dw_bad;
    verdict_t          vd;
    logic              open_q;
    logic              acc_q;

    assign fields = side_t'(in_side[PAR_LSB-1:0]);

    sfc_parity u_parity (
        .data   (in_data),
        .par    (in_side[SIDE_W-1:PAR_LSB]),
        .dw_bad (dw_bad)
    );

    sfc_frame_rules u_rules (
        .f       (fields),
        .cont    (open_q),
        .acc_bad (acc_q),
        .dw_bad  (dw_bad),
        .v       (vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            acc_q      <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            done_vld   <= 2'b00;
            done_good  <= 2'b00;
            pkt_count  <= '0;
        end else begin
            frame_err  <= in_valid & vd.err;
            parity_err <= in_valid & (|dw_bad);
            done_vld   <= in_valid ? vd.done : 2'b00;
            done_good  <= in_valid ? vd.good : 2'b00;
            if (in_valid) begin
                open_q    <= vd.open_nxt;
                acc_q     <= vd.acc_nxt;
                pkt_count <= pkt_count + CNT_W'(vd.done[0]) + CNT_W'(vd.done[1]);
            end
        end
    end

    assign pkt_open = open_q;

    // R7: second end slot never completes without the first
    p_done_order_r7: assert property (@(posedge clk) disable iff (rst)
        done_vld[1] |-> done_vld[0]);

    // R7: count advances exactly by the completions shown
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_count == $past(pkt_count) + CNT_W'($countones(done_vld)));

    // R9/R10: a verdict exists only for a completed packet
    p_good_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        (done_good & ~done_vld) == 2'b00);

    // R5: a framing error suppresses completions
    p_err_no_done_r5: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> (done_vld == 2'b00));

    // R2: unqualified beats leave no trace
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!frame_err && !parity_err && done_vld == 2'b00));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (pkt_open == $past(pkt_open) && pkt_count == $past(pkt_count)));

endmodule

// File: tb/straddle_frame_checker_tb.sv
module straddle_frame_checker_tb;
    import sfc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic [SIDE_W-1:0] in_side;
    logic              frame_err, parity_err, pkt_open;
    logic [1:0]        done_vld, done_good;
    logic [15:0]       pkt_count;

    int          checks = 0;
    int          errors = 0;
    int          beat_n = 0;
    logic [15:0] exp_cnt = '0;
    bit          finished = 0;

    always #5 clk = ~clk;

    straddle_frame_checker u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_side(in_side), .frame_err(frame_err), .parity_err(parity_err),
        .done_vld(done_vld), .done_good(done_good), .pkt_open(pkt_open),
        .pkt_count(pkt_count)
    );

    function automatic logic [BYTES-1:0] odd_par(input logic [DATA_W-1:0] d);
        logic [BYTES-1:0] p;
        for (int i = 0; i < BYTES; i++) p[i] = ~^d[8*i +: 8];
        return p;
    endfunction

    task automatic beat(input logic [1:0] s, input logic p0, input logic p1,
                        input logic [1:0] e, input logic [1:0] d,
                        input logic [2:0] o0, input logic [2:0] o1,
                        input logic [BYTES-1:0] flip);
        logic [31:0] pat;
        @(negedge clk);
        beat_n++;
        pat      = 32'h1234_5678 ^ (beat_n * 32'h0103_0507);
        in_data  = {8{pat}};
        in_side  = {odd_par({8{pat}}) ^ flip, o1, o0, d, e, p1, p0, s};
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic chk(input string req, input logic efe, input logic epe,
                       input logic [1:0] ed, input logic [1:0] eg, input logic eo);
        exp_cnt = exp_cnt + 16'(ed[0]) + 16'(ed[1]);
        checks++;
        if ({frame_err, parity_err, done_vld, done_good, pkt_open} !== {efe, epe, ed, eg, eo}
            || pkt_count !== exp_cnt) begin
            errors++;
            $display("FAIL %s: fe/pe/done/good/open/cnt actual %b %b %b %b %b %0d expected %b %b %b %b %b %0d",
                     req, frame_err, parity_err, done_vld, done_good, pkt_open, pkt_count,
                     efe, epe, ed, eg, eo, exp_cnt);
        end
    endtask

    task automatic idle(input string req, input logic eo);
        @(negedge clk);
        in_valid = 1'b0;
        in_side  = '1;
        in_data  = {8{32'hDEAD_BEEF}};
        @(posedge clk);
        #1 chk(req, 1'b0, 1'b0, 2'b00, 2'b00, eo);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_side = '0; in_data = '0;
        repeat (3) @(posedge clk);
        #1 chk("R1 in reset", 0, 0, 2'b00, 2'b00, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #1 chk("R1 after reset", 0, 0, 2'b00, 2'b00, 0);
    endtask

    task automatic t_single();
        beat(2'b01, 0, 0, 2'b01, 2'b00, 3'd7, 3'd0, '0);
        chk("R7 single beat packet", 0, 0, 2'b01, 2'b01, 0);
    endtask

    task automatic t_multi();
        beat(2'b01, 1, 0, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R11 open after start at dword 4", 0, 0, 2'b00, 2'b00, 1);
        idle("R2 invalid beat with illegal sideband", 1);
        beat(2'b00, 0, 0, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R11 continuation beat", 0, 0, 2'b00, 2'b00, 1);
        beat(2'b01, 1, 0, 2'b01, 2'b00, 3'd2, 3'd0, '0);
        chk("R6 end then start", 0, 0, 2'b01, 2'b01, 1);
        beat(2'b00, 0, 0, 2'b01, 2'b00, 3'd0, 3'd0, '0);
        chk("R7 end at dword 0", 0, 0, 2'b01, 2'b01, 0);
    endtask

    task automatic t_two_packets();
        beat(2'b11, 0, 1, 2'b11, 2'b00, 3'd3, 3'd7, '0);
        chk("R3 R4 two starts two ends", 0, 0, 2'b11, 2'b11, 0);
        beat(2'b11, 0, 1, 2'b01, 2'b00, 3'd1, 3'd0, '0);
        chk("R4 two starts one end", 0, 0, 2'b01, 2'b01, 1);
        beat(2'b01, 1, 0, 2'b11, 2'b00, 3'd2, 3'd6, '0);
        chk("R6 end start end", 0, 0, 2'b11, 2'b11, 0);
    endtask

    task automatic t_frame_errors();
        beat(2'b00, 0, 0, 2'b01, 2'b00, 3'd5, 3'd0, '0);
        chk("R5 end while closed", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b01, 0, 0, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R5 open", 0, 0, 2'b00, 2'b00, 1);
        beat(2'b01, 0, 0, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R5 start while open", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b10, 0, 1, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R3 start flags 10", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b01, 0, 0, 2'b10, 2'b00, 3'd7, 3'd7, '0);
        chk("R3 end flags 10", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b11, 1, 1, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R4 bad pointer pair", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b01, 0, 0, 2'b00, 2'b00, 3'd0, 3'd0, '0);
        chk("R6 open", 0, 0, 2'b00, 2'b00, 1);
        beat(2'b01, 1, 0, 2'b01, 2'b00, 3'd5, 3'd0, '0);
        chk("R6 end overlaps new start", 1, 0, 2'b00, 2'b00, 0);
        beat(2'b01, 1, 0, 2'b01, 2'b00, 3'd2, 3'd0, '0);
        chk("R6 end before own start", 1, 0, 2'b00, 2'b00, 0);
    endtask

    task automatic t_abort();
        beat(2'b01, 0, 0, 2'b00, 2'b01, 3'd0, 3'd0, '0);
        chk("R10 abort in first beat", 0, 0, 2'b00, 2'b00, 1);
        beat(2'b00, 0, 0, 2'b01, 2'b00, 3'd3, 3'd0, '0);
        chk("R10 aborted packet ends", 0, 0, 2'b01, 2'b00, 0);
        beat(2'b11, 0, 1, 2'b11, 2'b10, 3'd3, 3'd7, '0);
        chk("R10 second packet aborted", 0, 0, 2'b11, 2'b01, 0);
    endtask

    task automatic t_parity();
        beat(2'b01, 0, 0, 2'b01, 2'b00, 3'd7, 3'd0, 32'h0000_0020);
        chk("R8 R9 single packet bad byte", 0, 1, 2'b01, 2'b00, 0);
        beat(2'b11, 0, 1, 2'b11, 2'b00, 3'd3, 3'd7, 32'h0010_0000);
        chk("R9 bad byte in upper packet", 0, 1, 2'b11, 2'b01, 0);
        beat(2'b11, 0, 1, 2'b11, 2'b00, 3'd3, 3'd7, 32'h0000_0004);
        chk("R9 bad byte in lower packet", 0, 1, 2'b11, 2'b10, 0);
        beat(2'b01, 0, 0, 2'b00, 2'b00, 3'd0, 3'd0, 32'h0000_0001);
        chk("R8 bad byte in open packet", 0, 1, 2'b00, 2'b00, 1);
        beat(2'b00, 0, 0, 2'b01, 2'b00, 3'd7, 3'd0, '0);
        chk("R9 earlier parity fault held", 0, 0, 2'b01, 2'b00, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_two_packets();
        t_frame_errors();
        t_abort();
        t_parity();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule